// File: doc/BRIEF.md
# Fast Row-Mapped I/O Port

This block is an 8-bit fast I/O port that sits beside a chip's normal GPIO bank. It reaches many pads through one narrow register. Each port bit owns a row of pads: the pads whose number, taken modulo 8, equals that bit. A single write carries a set field and a clear field. Software can raise some rows, drop others, or load a whole byte in one access.

Each pad has a select bit that switches it from its normal output value to the fast row value. Pads in tristate output mode are locked out of fast operation. For input, each port bit reports the OR of the synchronized input levels of the fast-active pads in its row.

Top module: `fgp_port`

## Requirements
- R1: While reset is asserted, and after it is released, the fast latch `fast_q` is 0x00. The input synchronizer is also cleared, so `rd_data` reads 0x00 until new input levels have passed through it.
- R2: On a cycle with `wr_en`=1, a 1 in bit b of `wr_set` (with a 0 in the same bit of `wr_clr`) makes `fast_q[b]` 1 from the next clock edge. Bits with 0 in both fields keep their value.
- R3: On a cycle with `wr_en`=1, a 1 in bit b of `wr_clr` makes `fast_q[b]` 0 from the next clock edge.
- R4: When the same bit is 1 in both `wr_set` and `wr_clr` in one write, that bit of `fast_q` becomes 0.
- R5: A write with `wr_set`=v and `wr_clr`=v XOR 0xFF loads `fast_q` with exactly v in one cycle.
- R6: A pad n is fast-active when `pin_fast_sel[n]`=1 and `pin_tristate[n]`=0. Every fast-active pad drives `pad_out[n]` = `fast_q[n mod 8]`, so all active pads in a row change together.
- R7: A pad with `pin_tristate[n]`=1 drives `pad_out[n]` = `gpio_out[n]` even when selected. Its input never contributes to `rd_data`.
- R8: A pad with `pin_fast_sel[n]`=0 drives `pad_out[n]` = `gpio_out[n]`. Dropping the select returns the pad to its normal value at once.
- R9: `rd_data[b]` is the OR of the 2-stage synchronized `pad_in` levels of the fast-active pads in row b. It reads 0 when the row has no active pad. A change on `pad_in` appears after two clock edges.
- R10: On cycles with `wr_en`=0, `fast_q` holds its value whatever `wr_set` and `wr_clr` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the set/clear fields |
| wr_set | input | 8 | Bits to drive high |
| wr_clr | input | 8 | Bits to drive low (wins over set) |
| pin_fast_sel | input | NUM_PINS | Per-pad fast-mode select |
| pin_tristate | input | NUM_PINS | Per-pad tristate output mode flag |
| gpio_out | input | NUM_PINS | Normal GPIO output value per pad |
| pad_in | input | NUM_PINS | Raw pad input levels |
| fast_q | output | 8 | Fast output latch |
| rd_data | output | 8 | Row-gathered synchronized input |
| pad_out | output | NUM_PINS | Output value per pad |

## Verification
The latch is tested with a sequence of set/clear pairs in which each step is chosen to separate one rule from the others:
- set only versus clear only;
- both fields hitting the same bit, which separates clear-priority from set-priority or toggling;
- complementary pairs, which give a full byte load;
- an empty write.

Row fan-out is tested with one pad in a row against several pads in a row, and with pads at both ends of the pin range. This catches a wrong modulo or a wrong pin bound.

Selected tristate pads and unselected pads are mixed with active ones. This tells apart a wrong lockout, a missing revert and a wrong read-gather source. A pad is also raised on a row with no active pad, to confirm that such a row reads zero.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
  localparam int FGP_ROW_W = 8;
  typedef logic [FGP_ROW_W-1:0] row_vec_t;

  function automatic int row_of(input int pin);
    return pin % FGP_ROW_W;
  endfunction

  // clear has priority over set
  function automatic row_vec_t latch_next(input row_vec_t q, input row_vec_t s, input row_vec_t c);
    return (q | s) & ~c;
  endfunction
endpackage

// File: rtl/fgp_latch.sv
module fgp_latch
  import fgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  row_vec_t wr_set,
  input  row_vec_t wr_clr,
  output row_vec_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= latch_next(q, wr_set, wr_clr);
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(wr_set & ~wr_clr)) == $past(wr_set & ~wr_clr)));
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(wr_clr)) == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/fgp_sync.sv
module fgp_sync #(
  parameter int NUM_PINS = 50,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] d,
  output logic [NUM_PINS-1:0] q
);
  logic [NUM_PINS-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fgp_gather.sv
module fgp_gather
  import fgp_pkg::*;
#(
  parameter int NUM_PINS = 50
) (
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] active,
  output row_vec_t            rd
);
  always_comb begin
    rd = '0;
    for (int n = 0; n < NUM_PINS; n++)
      rd[row_of(n)] = rd[row_of(n)] | (level[n] & active[n]);
  end
endmodule

// File: rtl/fgp_port.sv
module fgp_port
  import fgp_pkg::*;
#(
  parameter int NUM_PINS    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [FGP_ROW_W-1:0] wr_set,
  input  logic [FGP_ROW_W-1:0] wr_clr,
  input  logic [NUM_PINS-1:0]  pin_fast_sel,
  input  logic [NUM_PINS-1:0]  pin_tristate,
  input  logic [NUM_PINS-1:0]  gpio_out,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [FGP_ROW_W-1:0] fast_q,
  output logic [FGP_ROW_W-1:0] rd_data,
  output logic [NUM_PINS-1:0]  pad_out
);
  logic [NUM_PINS-1:0] fast_act;
  logic [NUM_PINS-1:0] in_sync;

  assign fast_act = pin_fast_sel & ~pin_tristate;

  fgp_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_set(wr_set), .wr_clr(wr_clr), .q(fast_q)
  );

  fgp_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  fgp_gather #(.NUM_PINS(NUM_PINS)) u_gather (
    .level(in_sync), .active(fast_act), .rd(rd_data)
  );

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
      assign pad_out[n] = fast_act[n] ? fast_q[n % FGP_ROW_W] : gpio_out[n];

      assert_row_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fast_sel[n] && !pin_tristate[n]) |-> (pad_out[n] == fast_q[n % FGP_ROW_W]));
      assert_tristate_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_tristate[n] |-> (pad_out[n] == gpio_out[n]));
      assert_revert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_fast_sel[n] |-> (pad_out[n] == gpio_out[n]));
    end
  endgenerate

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_fast_sel & ~pin_tristate) == '0) |-> (rd_data == '0));
endmodule

// File: tb/fgp_port_tb.sv
module fgp_port_tb;
  localparam int NP = 50;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_set = 0, wr_clr = 0, fast_q, rd_data;
  logic [NP-1:0] sel = 0, tri_m = 0, gout = 0, pin = 0, pad_out;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model = 0;

  always #4 clk = ~clk;

  fgp_port #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_clr(wr_clr),
    .pin_fast_sel(sel), .pin_tristate(tri_m), .gpio_out(gout), .pad_in(pin),
    .fast_q(fast_q), .rd_data(rd_data), .pad_out(pad_out)
  );

  // {set, clr, expected latch}
  localparam logic [23:0] VEC [0:8] = '{
    {8'h01, 8'h00, 8'h01}, {8'h80, 8'h00, 8'h81}, {8'h00, 8'h01, 8'h80},
    {8'h0F, 8'h0F, 8'h80}, {8'hA5, 8'h5A, 8'hA5}, {8'h00, 8'h00, 8'hA5},
    {8'h3C, 8'hC3, 8'h3C}, {8'hFF, 8'h00, 8'hFF}, {8'h00, 8'hFF, 8'h00}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_pads(input logic [7:0] q);
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++)
      r[n] = (sel[n] && !tri_m[n]) ? q[n % 8] : gout[n];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [NP-1:0] lv);
    logic [7:0] r = 0;
    for (int n = 0; n < NP; n++)
      if (sel[n] && !tri_m[n] && lv[n]) r[n % 8] = 1'b1;
    return r;
  endfunction

  task automatic wr(input logic [7:0] s, input logic [7:0] c, input logic en);
    @(negedge clk);
    wr_en = en; wr_set = s; wr_clr = c;
    @(negedge clk);
    wr_en = 0; wr_set = 0; wr_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 latch in reset", fast_q, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 latch after reset", fast_q, 0);
    chk("R1 read after reset", rd_data, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][23:16], VEC[i][15:8], 1'b1);
      chk("R2 R3 R4 R5 latch table", fast_q, VEC[i][7:0]);
    end
    model = 8'h00;

    // R10 ignored fields without strobe
    wr(8'hFF, 8'h00, 1'b0);
    chk("R10 hold without wr_en", fast_q, 8'h00);

    // R5 full load then row fanout R6
    wr(8'h96, 8'h69, 1'b1); model = 8'h96;
    chk("R5 byte load", fast_q, 8'h96);
    sel = '0; sel[1] = 1; sel[9] = 1; sel[49] = 1; sel[2] = 1; sel[42] = 1; sel[7] = 1;
    gout = {NP{1'b1}};
    #1 chk("R6 row fanout", pad_out, exp_pads(model));
    wr(8'h00, 8'h02, 1'b1); model = 8'h94;
    chk("R6 row cleared together", pad_out, exp_pads(model));

    // R7 tristate lockout
    tri_m[9] = 1; tri_m[42] = 1;
    #1 chk("R7 tristate pads keep gpio value", pad_out, exp_pads(model));
    chk("R7 pad9 value", pad_out[9], 1'b1);

    // R8 revert
    sel[1] = 0;
    #1 chk("R8 deselected pad reverts", pad_out[1], 1'b1);
    gout = '0;
    #1 chk("R8 revert follows gpio_out", pad_out, exp_pads(model));

    // R9 read gather
    pin = '0; pin[49] = 1; pin[9] = 1; pin[42] = 1; pin[7] = 1; pin[20] = 1;
    @(negedge clk);
    chk("R9 one stage not yet visible", rd_data, 0);
    @(negedge clk);
    chk("R9 gathered read", rd_data, exp_rd(pin));
    chk("R9 exact value", rd_data, 8'h82);
    tri_m = '0;
    #1 chk("R7 tristate released adds row", rd_data, exp_rd(pin));
    sel = '0;
    #1 chk("R9 no active pad reads zero", rd_data, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule